// File: doc/BRIEF.md
# SPI Real-Time-Clock Register Slave

This block is the serial register front end of a small real-time-clock device. A host talks to it over a four-wire serial link. The chip select is active high. The link runs in mode 1: the clock idles low, both sides change data on the rising clock edge, and both sides sample on the falling edge. The first byte of each chip-select assertion is a command. Its upper nibble names a register and its lower nibble selects the access kind. The block then carries out a single-byte or auto-incrementing burst read or write against a sixteen-entry register space.

The register space holds seven BCD time registers and two control registers. A timekeeping core or a testbench sees the stored values as parallel outputs. Time writes are staged and applied together, so the time never shows a half-updated value. Two sticky status flags are set from input pulses. The host clears them by writing zero to their bit positions.

All serial inputs are resynchronised to the system clock. The serial clock must therefore be several times slower than the system clock.

Top module: `rtc_spi_regs`

## Requirements
- R1: The first byte of each chip-select assertion is the command. Bits 7:4 are the register address. Bits 3:0 select the access: 0x8 single write, 0xC single read, 0x0 burst write, 0x4 burst read. A command whose bits 1:0 are not 00 is rejected: the rest of that assertion writes nothing and MISO stays 0.
- R2: Chip select is active high and bytes travel MSB first. MOSI is sampled on the falling SCLK edge. MISO changes after the rising SCLK edge, returns 0 during the command byte, and is 0 while chip select is low.
- R3: Addresses 0 to 6 hold seconds, minutes, hours, weekday, day, month and year. Register n appears on time_regs[8n+7:8n]. Address 14 is control 1 (ctrl1_reg) and address 15 is control 2 (ctrl2_reg). Hours bit 5 (PM), month bit 7 (century) and control 1 bit 5 (24-hour select) are stored and read back unchanged.
- R4: A single access moves exactly one data byte. Any later bytes in the same assertion write nothing and read as 0.
- R5: A burst access moves to the next address after each data byte, and address 15 wraps to 0.
- R6: Addresses 7 to 13 read as 0, and writes to them change nothing.
- R7: Bytes written to the time registers are held back. All of them take effect together when chip select falls. A read within the same assertion returns the earlier values.
- R8: Seconds bit 7 is always 0, both on time_regs and on a read.
- R9: A pulse on osc_stop_evt sets control 2 bit 4, and a pulse on low_volt_evt sets control 2 bit 6. Both flags stay set until cleared.
- R10: A write to control 2 stores all bits except 4 and 6 directly. A 0 written to bit 4 or bit 6 clears that flag, and a 1 leaves it as it was.
- R11: A write to control 1 or control 2 takes effect at the end of its data byte, without waiting for chip select to fall.
- R12: After reset every register reads 0 and MISO is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_cs | input | 1 | Chip select, active high |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| osc_stop_evt | input | 1 | Pulse that sets the oscillator-stopped flag |
| low_volt_evt | input | 1 | Pulse that sets the low-voltage flag |
| time_regs | output | 56 | Seven committed time registers, seconds in the low byte |
| ctrl1_reg | output | 8 | Control register 1 |
| ctrl2_reg | output | 8 | Control register 2 with status flags |

## Verification
The assertions check on every cycle that the time outputs change only on the cycle after a commit, and that seconds bit 7 never rises. They also check that flag events always land, that a zero write clears a flag, that unimplemented addresses leave state untouched, that the ignore phase never writes, and that MISO is quiet outside an assertion. The bench scenarios cover what only a whole transaction can show: bit order, address-to-register mapping, burst stepping and wrap-around, rejection of bad commands, bytes discarded after a single access, and the contrast between staged time writes and immediate control writes.

// File: rtl/rtc_spi_pkg.sv
package rtc_spi_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = 4;
  localparam int TIME_REGS  = 7;
  localparam int CTRL1_ADDR = 14;
  localparam int CTRL2_ADDR = 15;
  localparam int OSC_BIT    = 4;
  localparam int LV_BIT     = 6;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {PH_CMD, PH_DATA, PH_IGNORE} phase_t;

  typedef struct packed {
    logic  ok;
    logic  single;
    logic  rd;
    addr_t addr;
  } cmd_t;

  // Split a command byte into address and access kind.
  function automatic cmd_t decode_cmd(byte_t b);
    cmd_t c;
    c.addr   = b[7:4];
    c.single = b[3];
    c.rd     = b[2];
    c.ok     = (b[1:0] == 2'b00);
    return c;
  endfunction

  // Burst address step; the natural overflow gives the 15 -> 0 wrap.
  function automatic addr_t step_addr(addr_t a);
    return a + addr_t'(1);
  endfunction

  // Bits that a write may set in each time register.
  function automatic byte_t time_keep_mask(int idx);
    return (idx == 0) ? byte_t'(8'h7F) : byte_t'(8'hFF);
  endfunction

  // Control 2 write: flag bits can only be cleared by a written zero.
  function automatic byte_t merge_ctrl2(byte_t cur, byte_t wr);
    byte_t r;
    r = wr;
    r[OSC_BIT] = cur[OSC_BIT] & wr[OSC_BIT];
    r[LV_BIT]  = cur[LV_BIT]  & wr[LV_BIT];
    return r;
  endfunction
endpackage

// File: rtl/rtc_spi_sync.sv
module rtc_spi_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) pipe[k] <= '0;
    end else begin
      pipe[0] <= din;
      for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/rtc_spi_shift.sv
module rtc_spi_shift
  import rtc_spi_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sclk_s,
  input  logic  cs_s,
  input  logic  mosi_s,
  input  logic  tx_load,
  input  byte_t tx_byte,
  output logic  miso,
  output logic  byte_done,
  output byte_t rx_byte,
  output logic  cs_rise,
  output logic  cs_fall
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic              sclk_d, cs_d;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] rx_sr;
  byte_t             tx_sr;
  logic              miso_q;

  // Named edge events, used by the logic and the assertions.
  wire lead_edge  = cs_s &  sclk_s & ~sclk_d;
  wire trail_edge = cs_s & ~sclk_s &  sclk_d;

  assign cs_rise   = cs_s & ~cs_d;
  assign cs_fall   = ~cs_s & cs_d;
  assign byte_done = trail_edge && (bit_cnt == CNT_W'(BYTE_W-1));
  assign rx_byte   = {rx_sr, mosi_s};
  assign miso      = miso_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      cs_d    <= 1'b0;
      bit_cnt <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      miso_q  <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
      if (cs_rise) begin
        bit_cnt <= '0;
        tx_sr   <= '0;
        miso_q  <= 1'b0;
      end else if (cs_fall) begin
        miso_q  <= 1'b0;
      end else begin
        if (tx_load) begin
          tx_sr <= tx_byte;
        end else if (lead_edge) begin
          miso_q <= tx_sr[BYTE_W-1];
          tx_sr  <= {tx_sr[BYTE_W-2:0], 1'b0};
        end
        if (trail_edge) begin
          rx_sr   <= {rx_sr[BYTE_W-3:0], mosi_s};
          bit_cnt <= bit_cnt + CNT_W'(1);
        end
      end
    end
  end

  // R2: no data leaves the block while chip select is inactive.
  p_miso_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && !cs_d) |-> !miso);

  // R2: every assertion starts counting bits from zero.
  p_bit_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> (bit_cnt == '0));
endmodule

// File: rtl/rtc_spi_regfile.sv
module rtc_spi_regfile
  import rtc_spi_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  addr_t                       wr_addr,
  input  byte_t                       wr_data,
  input  addr_t                       rd_addr,
  output byte_t                       rd_data,
  input  logic                        commit,
  input  logic                        osc_evt,
  input  logic                        lv_evt,
  output logic [TIME_REGS*BYTE_W-1:0] time_flat,
  output byte_t                       ctrl1,
  output byte_t                       ctrl2
);
  byte_t time_q  [TIME_REGS];
  byte_t stage_q [TIME_REGS];
  logic  dirty_q [TIME_REGS];

  wire wr_ctrl1 = wr_en && (wr_addr == addr_t'(CTRL1_ADDR));
  wire wr_ctrl2 = wr_en && (wr_addr == addr_t'(CTRL2_ADDR));
  wire wr_unimp = wr_en && (int'(wr_addr) >= TIME_REGS) && (int'(wr_addr) < CTRL1_ADDR);

  for (genvar i = 0; i < TIME_REGS; i++) begin : g_time
    localparam byte_t KEEP = time_keep_mask(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        time_q[i]  <= '0;
        stage_q[i] <= '0;
        dirty_q[i] <= 1'b0;
      end else begin
        if (wr_en && (wr_addr == addr_t'(i))) begin
          stage_q[i] <= wr_data & KEEP;
          dirty_q[i] <= 1'b1;
        end else if (commit) begin
          dirty_q[i] <= 1'b0;
        end
        if (commit && dirty_q[i]) time_q[i] <= stage_q[i];
      end
    end
    assign time_flat[i*BYTE_W +: BYTE_W] = time_q[i];
  end

  byte_t ctrl2_nxt;
  always_comb begin
    ctrl2_nxt = wr_ctrl2 ? merge_ctrl2(ctrl2, wr_data) : ctrl2;
    if (osc_evt) ctrl2_nxt[OSC_BIT] = 1'b1;
    if (lv_evt)  ctrl2_nxt[LV_BIT]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl1 <= '0;
      ctrl2 <= '0;
    end else begin
      if (wr_ctrl1) ctrl1 <= wr_data;
      ctrl2 <= ctrl2_nxt;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < TIME_REGS; i++)
      if (rd_addr == addr_t'(i)) rd_data = time_q[i];
    if (rd_addr == addr_t'(CTRL1_ADDR)) rd_data = ctrl1;
    if (rd_addr == addr_t'(CTRL2_ADDR)) rd_data = ctrl2;
  end

  // R7: time outputs only move on the cycle after a commit.
  p_time_atomic_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(time_flat) |-> $past(commit));

  // R8: seconds bit 7 never appears.
  p_sec_msb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !time_flat[BYTE_W-1]);

  // R9: flag events always land.
  p_osc_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    osc_evt |=> ctrl2[OSC_BIT]);
  p_lv_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lv_evt |=> ctrl2[LV_BIT]);

  // R10: a zero written to a flag clears it when no event competes.
  p_osc_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl2 && !wr_data[OSC_BIT] && !osc_evt) |=> !ctrl2[OSC_BIT]);

  // R6: writes to the hole leave every register alone.
  p_unimp_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_unimp && !osc_evt && !lv_evt && !commit) |=>
      ($stable(ctrl1) && $stable(ctrl2) && $stable(time_flat)));
endmodule

// File: rtl/rtc_spi_regs.sv
module rtc_spi_regs
  import rtc_spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        spi_sclk,
  input  logic                        spi_cs,
  input  logic                        spi_mosi,
  output logic                        spi_miso,
  input  logic                        osc_stop_evt,
  input  logic                        low_volt_evt,
  output logic [TIME_REGS*BYTE_W-1:0] time_regs,
  output logic [BYTE_W-1:0]           ctrl1_reg,
  output logic [BYTE_W-1:0]           ctrl2_reg
);
  logic [2:0] sync_bus;
  logic       sclk_s, cs_s, mosi_s;

  rtc_spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({spi_sclk, spi_cs, spi_mosi}),
    .dout (sync_bus)
  );
  assign {sclk_s, cs_s, mosi_s} = sync_bus;

  logic  tx_load, byte_done, cs_rise, cs_fall;
  byte_t tx_byte, rx_byte;

  rtc_spi_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_s   (sclk_s),
    .cs_s     (cs_s),
    .mosi_s   (mosi_s),
    .tx_load  (tx_load),
    .tx_byte  (tx_byte),
    .miso     (spi_miso),
    .byte_done(byte_done),
    .rx_byte  (rx_byte),
    .cs_rise  (cs_rise),
    .cs_fall  (cs_fall)
  );

  phase_t phase_q, phase_d;
  addr_t  addr_q, addr_d, rd_addr;
  logic   single_q, single_d, rd_q, rd_d;
  logic   wr_en;
  byte_t  rd_data;
  cmd_t   cmd_now;

  assign cmd_now = decode_cmd(rx_byte);
  assign rd_addr = (phase_q == PH_CMD) ? cmd_now.addr : step_addr(addr_q);

  always_comb begin
    phase_d  = phase_q;
    addr_d   = addr_q;
    single_d = single_q;
    rd_d     = rd_q;
    wr_en    = 1'b0;
    tx_load  = 1'b0;
    tx_byte  = '0;
    if (cs_rise) begin
      phase_d = PH_CMD;
    end else if (byte_done) begin
      case (phase_q)
        PH_CMD: begin
          if (!cmd_now.ok) begin
            phase_d = PH_IGNORE;
          end else begin
            phase_d  = PH_DATA;
            addr_d   = cmd_now.addr;
            single_d = cmd_now.single;
            rd_d     = cmd_now.rd;
            if (cmd_now.rd) begin
              tx_load = 1'b1;
              tx_byte = rd_data;
            end
          end
        end
        PH_DATA: begin
          wr_en = !rd_q;
          if (single_q) begin
            phase_d = PH_IGNORE;
            tx_load = rd_q;
          end else begin
            addr_d = step_addr(addr_q);
            if (rd_q) begin
              tx_load = 1'b1;
              tx_byte = rd_data;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_CMD;
      addr_q   <= '0;
      single_q <= 1'b0;
      rd_q     <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      addr_q   <= addr_d;
      single_q <= single_d;
      rd_q     <= rd_d;
    end
  end

  rtc_spi_regfile u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (addr_q),
    .wr_data  (rx_byte),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .commit   (cs_fall),
    .osc_evt  (osc_stop_evt),
    .lv_evt   (low_volt_evt),
    .time_flat(time_regs),
    .ctrl1    (ctrl1_reg),
    .ctrl2    (ctrl2_reg)
  );

  // R1: a fresh assertion always starts by expecting a command.
  p_cmd_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> (phase_q == PH_CMD));

  // R4: nothing is written once the access has been used up or rejected.
  p_ignore_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IGNORE) |-> !wr_en);

  // R5: a burst leaving address 15 continues at address 0.
  p_burst_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !cs_rise && phase_q == PH_DATA && !single_q && addr_q == addr_t'(15))
      |=> (addr_q == '0));
endmodule

// File: tb/tb_rtc_spi_regs.sv
module tb_rtc_spi_regs;
  localparam int HALF = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_sclk = 1'b0, spi_cs = 1'b0, spi_mosi = 1'b0;
  logic        spi_miso;
  logic        osc_stop_evt = 1'b0, low_volt_evt = 1'b0;
  logic [55:0] time_regs;
  logic [7:0]  ctrl1_reg, ctrl2_reg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_spi_regs dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs(spi_cs),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .osc_stop_evt(osc_stop_evt),
    .low_volt_evt(low_volt_evt), .time_regs(time_regs),
    .ctrl1_reg(ctrl1_reg), .ctrl2_reg(ctrl2_reg)
  );

  // {address, written byte, expected readback}
  localparam logic [23:0] VEC [10] = '{
    24'h00_D9_59, 24'h01_45_45, 24'h02_32_32, 24'h03_06_06, 24'h04_31_31,
    24'h05_92_92, 24'h06_99_99, 24'h07_AA_00, 24'h0C_5A_00, 24'h0E_20_20
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic spi_begin();
    @(negedge clk);
    spi_cs = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      spi_sclk = 1'b1;
      spi_mosi = tx[b];
      repeat (HALF) @(negedge clk);
      rx[b] = spi_miso;
      spi_sclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic spi_end();
    spi_cs = 1'b0;
    spi_mosi = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic pulse(input bit osc);
    @(negedge clk);
    if (osc) osc_stop_evt = 1'b1; else low_volt_evt = 1'b1;
    @(negedge clk);
    osc_stop_evt = 1'b0;
    low_volt_evt = 1'b0;
    @(negedge clk);
  endtask

  task automatic single_write(input logic [3:0] a, input logic [7:0] d);
    logic [7:0] rx;
    spi_begin();
    spi_byte({a, 4'h8}, rx);
    spi_byte(d, rx);
    spi_end();
  endtask

  task automatic single_read(input logic [3:0] a, output logic [7:0] d);
    logic [7:0] rx;
    spi_begin();
    spi_byte({a, 4'hC}, rx);
    spi_byte(8'h00, d);
    spi_end();
  endtask

  initial begin
    logic [7:0] rx;
    logic [7:0] exp_burst [7];
    exp_burst = '{8'h11, 8'h22, 8'h23, 8'h04, 8'h15, 8'h06, 8'h25};
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12 reset state
    check("R12 time_regs", time_regs, 0);
    check("R12 ctrl1", ctrl1_reg, 0);
    check("R12 ctrl2", ctrl2_reg, 0);
    check("R12 miso", spi_miso, 0);

    // Table: R3 mapping, R6 hole, R8 seconds bit 7, MSB-first R2
    for (int i = 0; i < 10; i++) begin
      logic [3:0] a;
      a = VEC[i][19:16];
      single_write(a, VEC[i][15:8]);
      single_read(a, rx);
      check($sformatf("R3/R6/R8 readback addr %0d", a), rx, VEC[i][7:0]);
      if (a < 7) check($sformatf("R3 time_regs slot %0d", a), time_regs[8*a +: 8], VEC[i][7:0]);
      if (a == 14) check("R3 ctrl1 output", ctrl1_reg, VEC[i][7:0]);
    end
    check("R2 miso low after release", spi_miso, 0);

    // R7 staged burst write, committed on release
    spi_begin();
    spi_byte(8'h00, rx);
    for (int i = 0; i < 7; i++) spi_byte(exp_burst[i], rx);
    check("R7 time held until release", time_regs, 56'h99_92_31_06_32_45_59);
    spi_end();
    check("R7 time committed", time_regs, 56'h25_06_15_04_23_22_11);

    // R5 burst read plus one step into the hole
    spi_begin();
    spi_byte(8'h04, rx);
    check("R2 miso zero during command", rx, 0);
    for (int i = 0; i < 7; i++) begin
      spi_byte(8'h00, rx);
      check($sformatf("R5 burst read byte %0d", i), rx, exp_burst[i]);
    end
    spi_byte(8'h00, rx);
    check("R6 burst into address 7", rx, 0);
    spi_end();

    // R9 flags
    pulse(1'b1);
    check("R9 oscillator flag", ctrl2_reg, 8'h10);
    pulse(1'b0);
    check("R9 low-voltage flag", ctrl2_reg, 8'h50);

    // R5 wrap: burst read from 14 runs 14, 15, 0
    spi_begin();
    spi_byte(8'hE4, rx);
    spi_byte(8'h00, rx);
    check("R5 wrap ctrl1", rx, 8'h20);
    spi_byte(8'h00, rx);
    check("R5 wrap ctrl2", rx, 8'h50);
    spi_byte(8'h00, rx);
    check("R5 wrap to seconds", rx, 8'h11);
    spi_end();

    // R10 write-zero-to-clear
    single_write(4'hF, 8'hFC);
    check("R10 ones keep flags", ctrl2_reg, 8'hFC);
    single_write(4'hF, 8'hAF);
    check("R10 zeros clear flags", ctrl2_reg, 8'hAF);
    single_write(4'hF, 8'h50);
    check("R10 ones cannot set flags", ctrl2_reg, 8'h00);

    // R4 single write with trailing byte
    spi_begin();
    spi_byte(8'h18, rx);
    spi_byte(8'h33, rx);
    spi_byte(8'h44, rx);
    spi_end();
    check("R4 minutes written once", time_regs[15:8], 8'h33);
    check("R4 hours untouched", time_regs[23:16], 8'h23);

    // R4 single read with trailing byte
    spi_begin();
    spi_byte(8'h2C, rx);
    spi_byte(8'h00, rx);
    check("R4 single read data", rx, 8'h23);
    spi_byte(8'h00, rx);
    check("R4 trailing byte reads zero", rx, 0);
    spi_end();

    // R1 rejected command
    spi_begin();
    spi_byte(8'h3A, rx);
    spi_byte(8'h77, rx);
    check("R1 rejected command miso", rx, 0);
    spi_end();
    check("R1 weekday untouched", time_regs[31:24], 8'h04);

    // R11 control write is immediate
    spi_begin();
    spi_byte(8'hE8, rx);
    spi_byte(8'h00, rx);
    check("R11 ctrl1 before release", ctrl1_reg, 8'h00);
    spi_end();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule